// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs one complete SPI flash transaction each time software asks for it. Software uses a small 32-bit register bus to load three words. The first is a command word that holds the flash opcode and a 24-bit address. The second is a data word that supplies extra transmit bytes or collects received bytes. The third is a control word that sets the byte counts and the SCLK rate. Setting the start bit in the control word lowers chip select and clocks out the transmit bytes in SPI mode 0. The block then clocks in the requested receive bytes and raises chip select again. A busy flag in the control word stays set for the whole frame.

A single start covers a frame of up to twelve bytes. The transmit bytes come first from the command word and then from the data word. The received bytes are packed into the data word starting at its lowest byte. The data word is little endian: its byte 0 is the first data byte on the wire. Software checks the busy flag to see when the frame is done, then reads the data word and masks off the bytes beyond its receive count. The register bus is a plain address/strobe interface with no handshake, so this block has no valid/ready edge. A read returns data in the cycle the read strobe is high. A write takes effect at the clock edge where the write strobe is high.

Top module: `spi_cmd_engine`

## Requirements
- R1: The register offsets are 0x0 for control, 0x4 for the command word and 0x8 for the data word. In the control word, the transmit count is bits [3:0], the receive count is bits [7:4], the size field is bits [18:17] and the SCLK select is bits [25:24]. All four fields read back as written. Bit 8 and all other unlisted bits read 0, except bit 16.
- R2: An idle write to control with bit 8 set and a nonzero count starts a frame. Control bit 16 then reads 1 and chip select (active low) stays low until the frame ends.
- R3: The bus follows SPI mode 0. SCLK is low whenever chip select is high. MOSI holds steady while SCLK is high. MISO is captured on the rising edge of SCLK.
- R4: Chip select falls one SCLK half-period before the first rising edge of SCLK. It rises at the same clock edge where SCLK falls for the last time.
- R5: The wire order of transmit bytes is: command bits [7:0], then [31:24], [23:16], [15:8], then data word bytes 0, 1, 2, 3. Each byte goes MSB first. A transmit count of N sends the first N bytes of this order. MOSI is 0 while bytes are being received.
- R6: Received byte j is written to data word bits [8j+7:8j], taking the first wire bit as the MSB. Bytes at or above the receive count are undefined.
- R7: SCLK select codes 0, 1, 2 and 3 give an SCLK period of 2, 4, 8 and 16 system clocks. Chip select stays low for exactly 8·(tx+rx)·period clocks.
- R8: A transmit count above 8 acts as 8. A receive count above 4 acts as 4.
- R9: A start with both counts zero is ignored: chip select stays high and busy stays 0.
- R10: While busy, writes to any register are ignored, including a new start.
- R11: After reset, all registers read 0, chip select is high, and SCLK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, otherwise 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps every pair of transmit count 0–8 and receive count 0–4. The SCLK select changes with each pair, and the command, data and slave patterns change as well. Each pair therefore tests byte order across the point where the command word ends and the data word begins, the MSB-first bit order, and the point where transmit ends and receive begins. Each transmit frame is compared bit by bit with a frame built arithmetically in the bench. Each received data word is compared with the slave's pattern under the byte mask. The length of the chip-select window tells a wrong divider apart from a wrong frame length. Separate cases cover out-of-range counts (clamping), a zero-length start, and writes issued during a frame (the read-back command and control words must be unchanged).

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int REG_AW = 4;
  localparam int WORD_W = 32;
  localparam int SEL_W = 2;
  localparam int CNT_W = 4;
  localparam int MAX_TX_BYTES = 8;
  localparam int MAX_RX_BYTES = 4;
  localparam int FRAME_W = MAX_TX_BYTES * 8;
  localparam int BITCNT_W = $clog2((MAX_TX_BYTES + MAX_RX_BYTES) * 8 + 1);
  localparam int RXPOS_W = $clog2(MAX_RX_BYTES * 8);

  localparam logic [REG_AW-1:0] OFF_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFF_CMDW = 4'h4;
  localparam logic [REG_AW-1:0] OFF_DATA = 4'h8;

  localparam int B_GO = 8;
  localparam int B_BUSY = 16;
  localparam int B_SIZE = 17;
  localparam int B_SEL = 24;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [1:0]       size;
    logic [CNT_W-1:0] rx_cnt;
    logic [CNT_W-1:0] tx_cnt;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v,
                                                 input int lim);
    return (int'(v) > lim) ? CNT_W'(lim) : v;
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             tick
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt_q;
  logic [CW:0]      lim;

  // half-period in system clocks is 2**sel
  assign lim  = ({{CW{1'b0}}, 1'b1} << sel_q) - 1'b1;
  assign tick = run && ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (start) sel_q <= sel;
      if (!run || tick) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   tx_bytes,
  input  logic [CNT_W-1:0]   rx_bytes,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic               tick,
  input  logic               miso,
  output logic               busy,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               rx_we,
  output logic [RXPOS_W-1:0] rx_pos,
  output logic               rx_bit
);
  logic                busy_q, sclk_q;
  logic [BITCNT_W-1:0] bit_q, last_q, txb_q, tot;
  logic [FRAME_W-1:0]  shreg_q;
  logic [RXPOS_W-1:0]  rel;
  logic                in_tx;

  assign tot   = (BITCNT_W'(tx_bytes) << 3) + (BITCNT_W'(rx_bytes) << 3);
  assign in_tx = bit_q < txb_q;
  assign rel   = bit_q[RXPOS_W-1:0] - txb_q[RXPOS_W-1:0];

  assign busy   = busy_q;
  assign cs_n   = !busy_q;
  assign sclk   = sclk_q;
  assign mosi   = busy_q && in_tx && shreg_q[FRAME_W-1];
  // capture at the edge where SCLK rises; first wire bit lands in the byte MSB
  assign rx_we  = busy_q && tick && !sclk_q && !in_tx;
  assign rx_pos = {rel[RXPOS_W-1:3], ~rel[2:0]};
  assign rx_bit = miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      bit_q   <= '0;
      last_q  <= '0;
      txb_q   <= '0;
      shreg_q <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      bit_q   <= '0;
      last_q  <= tot - 1'b1;
      txb_q   <= BITCNT_W'(tx_bytes) << 3;
      shreg_q <= tx_frame;
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == last_q) begin
          busy_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + 1'b1;
          shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               busy,
  input  logic               rx_we,
  input  logic [RXPOS_W-1:0] rx_pos,
  input  logic               rx_bit,
  output logic               start,
  output logic [CNT_W-1:0]   tx_eff,
  output logic [CNT_W-1:0]   rx_eff,
  output logic [SEL_W-1:0]   sel,
  output logic [FRAME_W-1:0] tx_frame
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [WORD_W-1:0] cmd_q, data_q;
  logic              wr_ok;

  assign wr_ok  = bus_wr && !busy;
  assign ctrl_d = '{sel:    bus_wdata[B_SEL +: SEL_W],
                    size:   bus_wdata[B_SIZE +: 2],
                    rx_cnt: bus_wdata[7:4],
                    tx_cnt: bus_wdata[3:0]};

  assign tx_eff = clamp_cnt(ctrl_d.tx_cnt, MAX_TX_BYTES);
  assign rx_eff = clamp_cnt(ctrl_d.rx_cnt, MAX_RX_BYTES);
  assign sel    = ctrl_d.sel;
  assign start  = wr_ok && (bus_addr == OFF_CTRL) && bus_wdata[B_GO] &&
                  ((ctrl_d.tx_cnt != '0) || (ctrl_d.rx_cnt != '0));

  // opcode first, then address high to low, then data bytes 0..3
  always_comb begin
    tx_frame[FRAME_W-1 -: 8]  = cmd_q[7:0];
    tx_frame[FRAME_W-9 -: 8]  = cmd_q[31:24];
    tx_frame[FRAME_W-17 -: 8] = cmd_q[23:16];
    tx_frame[FRAME_W-25 -: 8] = cmd_q[15:8];
    for (int k = 0; k < 4; k++) tx_frame[31 - 8*k -: 8] = data_q[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ok && bus_addr == OFF_CTRL) ctrl_q <= ctrl_d;
      if (wr_ok && bus_addr == OFF_CMDW) cmd_q <= bus_wdata;
      if (rx_we) data_q[rx_pos] <= rx_bit;
      else if (wr_ok && bus_addr == OFF_DATA) data_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFF_CTRL: bus_rdata = {6'b0, ctrl_q.sel, 5'b0, ctrl_q.size, busy, 8'b0,
                               ctrl_q.rx_cnt, ctrl_q.tx_cnt};
        OFF_CMDW: bus_rdata = cmd_q;
        OFF_DATA: bus_rdata = data_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic               start, busy, tick, rx_we, rx_bit;
  logic [CNT_W-1:0]   tx_eff, rx_eff;
  logic [SEL_W-1:0]   sel;
  logic [FRAME_W-1:0] tx_frame;
  logic [RXPOS_W-1:0] rx_pos;

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit),
    .start(start), .tx_eff(tx_eff), .rx_eff(rx_eff), .sel(sel),
    .tx_frame(tx_frame)
  );

  spi_clk_div u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .run(busy),
    .tick(tick)
  );

  spi_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_bytes(tx_eff),
    .rx_bytes(rx_eff), .tx_frame(tx_frame), .tick(tick), .miso(spi_miso),
    .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit)
  );
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker
  import spi_cmd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic               spi_cs_n,
  input logic               spi_sclk,
  input logic               spi_mosi,
  input logic               busy,
  input logic [FRAME_W-1:0] tx_frame
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi)); // R3
  AST_CS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $past(!spi_cs_n)); // R4
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $fell(spi_sclk)); // R4
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && bus_addr == OFF_CTRL && bus_wdata[B_GO] &&
     bus_wdata[7:0] == 8'h00 && spi_cs_n) |=> spi_cs_n); // R9
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == OFF_CMDW) |=> $stable(tx_frame[FRAME_W-1 -: 32])); // R10
endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .busy(busy), .tx_frame(tx_frame)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int n_tests = 0, n_fail = 0;
  logic [95:0] miso_stream = '0;
  logic [95:0] mosi_log = '0;
  int rise_cnt = 0;
  int low_cycles = 0;

  always #10 clk = ~clk;

  spi_cmd_engine dut (.*);

  // slave model: presents bit k of the stream before rising edge k
  assign spi_miso = (rise_cnt < 96) ? miso_stream[95 - rise_cnt] : 1'b0;
  always @(posedge spi_sclk) begin
    mosi_log = {mosi_log[94:0], spi_mosi};
    rise_cnt = rise_cnt + 1;
  end
  always @(posedge clk) if (!spi_cs_n) low_cycles = low_cycles + 1;

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      bus_read(4'h0, v);
      if (!v[16]) return;
    end
  endtask

  task automatic clear_logs();
    mosi_log = '0; rise_cnt = 0; low_cycles = 0;
  endtask

  task automatic run_frame(input int tx, input int rx, input int sel,
                           input logic [31:0] cmd, input logic [31:0] dat,
                           input logic [95:0] stream);
    int txe, rxe, bits;
    logic [63:0] exp_tx;
    logic [95:0] exp_log, mask;
    logic [31:0] v, exp_d, dmask;
    txe = (tx > 8) ? 8 : tx;
    rxe = (rx > 4) ? 4 : rx;
    bits = 8 * (txe + rxe);
    bus_write(4'h4, cmd);
    bus_write(4'h8, dat);
    miso_stream = stream;
    clear_logs();
    bus_write(4'h0, (32'(sel) << 24) | (32'(rx) << 4) | 32'(tx) | 32'h100);
    bus_read(4'h0, v);
    check("R2 busy flag", {95'b0, v[16]}, 96'd1);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R7 rising edge count", 96'(rise_cnt), 96'(bits));
    check("R7 cs low cycles", 96'(low_cycles), 96'(bits * 2 * (1 << sel)));
    exp_tx = {cmd[7:0], cmd[31:24], cmd[23:16], cmd[15:8],
              dat[7:0], dat[15:8], dat[23:16], dat[31:24]};
    exp_log = '0; mask = '0;
    for (int i = 0; i < bits; i++) begin
      exp_log[bits - 1 - i] = (i < 8 * txe) ? exp_tx[63 - i] : 1'b0;
      mask[i] = 1'b1;
    end
    check("R5 mosi frame", mosi_log & mask, exp_log);
    exp_d = '0; dmask = '0;
    for (int j = 0; j < rxe; j++) begin
      exp_d[8*j +: 8] = stream[95 - 8*(txe + j) -: 8];
      dmask[8*j +: 8] = 8'hFF;
    end
    bus_read(4'h8, v);
    check("R6 rx packing", 96'(v & dmask), 96'(exp_d));
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    bus_read(4'h0, v); check("R11 ctrl reset", 96'(v), 96'd0);
    bus_read(4'h4, v); check("R11 cmd reset", 96'(v), 96'd0);
    bus_read(4'h8, v); check("R11 data reset", 96'(v), 96'd0);
    check("R11 pins", {93'b0, spi_cs_n, spi_sclk, spi_mosi}, 96'b100);

    // R1 field readback, no start bit
    bus_write(4'h0, 32'hFFFF_FEFF);
    bus_read(4'h0, v); check("R1 ctrl readback", 96'(v), 96'h0306_00FF);
    check("R1 no frame", {95'b0, spi_cs_n}, 96'd1);
    bus_write(4'h4, 32'h1234_5678);
    bus_read(4'h4, v); check("R1 cmd readback", 96'(v), 96'h1234_5678);

    // R9 zero-length start
    clear_logs();
    bus_write(4'h0, 32'h0000_0100);
    repeat (4) @(negedge clk);
    bus_read(4'h0, v);
    check("R9 busy stays clear", {95'b0, v[16]}, 96'd0);
    check("R9 no cs activity", 96'(low_cycles), 96'd0);

    // sweep of all count pairs (R3 R4 R5 R6 R7)
    for (int tx = 0; tx <= 8; tx++) begin
      for (int rx = 0; rx <= 4; rx++) begin
        if (tx + rx > 0) begin
          logic [31:0] c, d;
          c = 32'hA1B2_C3D4 ^ (32'(tx) * 32'h0101_0101) ^ (32'(rx) << 13);
          d = 32'h9E37_79B9 + 32'(tx * 7 + rx) * 32'h1357_9BDF;
          run_frame(tx, rx, (tx + rx) % 4, c, d,
                    {c ^ 32'h5A5A_5A5A, d ^ 32'hC33C_0FF0, ~c});
        end
      end
    end

    // R8 count clamping
    run_frame(15, 9, 0, 32'hDEAD_BEEF, 32'h0BAD_F00D,
              96'h0123_4567_89AB_CDEF_F0E1_D2C3);

    // R10 writes during a frame are ignored
    bus_write(4'h4, 32'h5500_AA03);
    clear_logs();
    bus_write(4'h0, 32'h0300_0112);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'h0000_0188);
    wait_idle();
    repeat (2) @(negedge clk);
    bus_read(4'h4, v); check("R10 cmd unchanged", 96'(v), 96'h5500_AA03);
    bus_read(4'h0, v); check("R10 ctrl unchanged", 96'(v), 96'h0300_0012);
    check("R10 frame length kept", 96'(rise_cnt), 96'd24);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule